// File: doc/BRIEF.md
# Eight-Channel Balanced Dimming PWM Generator

This block drives eight digital dimming outputs for lamp inverter channels. A single master brightness value sets the duty cycle of all eight outputs. Each channel adds its own signed trim to that value, so lamps that age or sit in different places can be matched. The sum is clamped to the legal duty range. All channels share one 256-step frame. The frame comes either from a programmable internal prescaler or from rising edges on an external sync input, so the dimming rate can follow a video timing source.

A plain synchronous write port (address, data, strobe) loads the settings. A 3-bit status output reports lamp fault, lost sync and the effective enable. New duty values are taken only at a frame boundary. A lamp-on feedback watchdog shuts every output down if the lamps fail to strike within a programmed number of clocks after enable.

Top module: `dim_pwm_bank`

## Requirements
- R1: For each channel k, the effective duty is master plus the offset of channel k, clamped to 0..255. Over one frame the output is high for duty×(P+1) clocks, where P is the prescale value. A duty of 255 gives an output that is high for the whole frame.
- R2: An effective duty of 0 keeps the output low at all times, and an effective duty of 255 keeps it high at all times.
- R3: The offsets sit at addresses 8+k in data bits 7:0, as signed two's complement. A negative sum clamps to 0 and a sum above 255 clamps to 255.
- R4: In internal mode, with the prescale value P in bits 15:0 at address 2, one frame lasts 256×(P+1) clocks. The phase wraps from 255 to 0.
- R5: A new master or offset value changes an output only from the start of the next frame. The frame in progress keeps the old duty.
- R6: At address 0, bit 0 is the software enable. When en_i is low or that bit is clear, every output goes low one clock later, and status bit 2 shows the AND of the two enables.
- R7: In external mode (bit 1 at address 0 set), a rising edge of sync_i, after a two-flop synchronizer, restarts the frame at phase 0. Between edges the phase advances and then holds at 255.
- R8: In external mode, if no edge arrives within 512 clocks, all outputs go low and status bit 1 is set. The next edge clears the bit and restarts output.
- R9: If lamp_on_i is not seen within the number of clocks set in bits 15:0 at address 3 after the effective enable rises, status bit 0 is set and all outputs are held low.
- R10: The fault clears only on a write of 1 to bit 2 at address 0, or when the effective enable drops. The lamp feedback returning later does not clear it.
- R11: After reset all outputs are low and the status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global output enable |
| lamp_on_i | input | 1 | Lamp-struck feedback (asynchronous) |
| sync_i | input | 1 | External frame sync (asynchronous) |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 16 | Register write data |
| pwm_o | output | 8 | Dimming outputs, channel k on bit k |
| status_o | output | 3 | {enable, sync lost, fault} |

## Verification
The main function is driven by a table of master and offset patterns. The table holds uniform offsets, rising and falling offset ramps, ramps that clip at the bottom or top of the range, and the 0 and 255 limits, each run at several prescale values. Counting high cycles over a full frame separates correct addition and clamping from wraparound, and it also shows whether the prescaler scales the frame. In external mode, a sync period of 200 clocks combined with a duty above 200 shows that edges restart the phase instead of letting it wrap. A write in the middle of a frame, followed by samples before and after the next boundary, separates deferred loading from immediate loading.

// File: rtl/dim_pkg.sv
package dim_pkg;
  localparam int CH_N       = 8;
  localparam int DUTY_W     = 8;
  localparam int PSC_W      = 16;
  localparam int TMO_W      = 16;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 16;
  localparam int SYNC_LIMIT = 512;
  localparam int OFF_BASE   = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_MASTER = 4'd1;
  localparam logic [ADDR_W-1:0] A_PSC    = 4'd2;
  localparam logic [ADDR_W-1:0] A_TMO    = 4'd3;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_EXT_BIT = 1;
  localparam int CTRL_CLR_BIT = 2;

  typedef struct packed {
    logic ext;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/dim_sync2.sv
module dim_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/dim_regs.sv
module dim_regs
  import dim_pkg::*;
#(
  parameter int N      = CH_N,
  parameter int DW     = DUTY_W,
  parameter int PW     = PSC_W,
  parameter int TW     = TMO_W,
  parameter int AW     = ADDR_W,
  parameter int WW     = DATA_W,
  parameter int OBASE  = OFF_BASE
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [WW-1:0]         wdata_i,
  output ctrl_t                 ctrl_o,
  output logic                  fault_clr_o,
  output logic [DW-1:0]         master_o,
  output logic [N-1:0][DW-1:0]  off_o,
  output logic [PW-1:0]         psc_o,
  output logic [TW-1:0]         tmo_o
);
  logic wr_ctrl;
  assign wr_ctrl     = we_i && (addr_i == A_CTRL);
  assign fault_clr_o = wr_ctrl && wdata_i[CTRL_CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= '0;
      master_o <= '0;
      psc_o    <= '0;
      tmo_o    <= '1;
    end else if (we_i) begin
      if (addr_i == A_CTRL) begin
        ctrl_o.en  <= wdata_i[CTRL_EN_BIT];
        ctrl_o.ext <= wdata_i[CTRL_EXT_BIT];
      end
      if (addr_i == A_MASTER) master_o <= wdata_i[DW-1:0];
      if (addr_i == A_PSC)    psc_o    <= wdata_i[PW-1:0];
      if (addr_i == A_TMO)    tmo_o    <= wdata_i[TW-1:0];
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_off
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    off_o[k] <= '0;
      else if (we_i && (addr_i == AW'(OBASE + k)))    off_o[k] <= wdata_i[DW-1:0];
    end
  end
endmodule

// File: rtl/dim_fault.sv
module dim_fault #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          lamp_i,
  input  logic          clr_i,
  input  logic [TW-1:0] tmo_i,
  output logic          fault_o
);
  logic [TW-1:0] cnt_q;
  logic          seen_q;
  logic          fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      fault_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      fault_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
      seen_q  <= seen_q | lamp_i;
    end else if (lamp_i) begin
      seen_q  <= 1'b1;
    end else if (!seen_q && !fault_q) begin
      if (cnt_q == tmo_i) fault_q <= 1'b1;
      else                cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign fault_o = fault_q;

  // R10: sticky until clear strobe or enable loss
  a_r10_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q && en_i && !clr_i |=> fault_q);
endmodule

// File: rtl/dim_timebase.sv
module dim_timebase #(
  parameter int DW      = 8,
  parameter int PW      = 16,
  parameter int SYNC_LIM = 512
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          ext_mode_i,
  input  logic          sync_rise_i,
  input  logic [PW-1:0] psc_i,
  output logic [DW-1:0] phase_o,
  output logic          load_o,
  output logic          run_o,
  output logic          lost_o
);
  localparam int SC_W = $clog2(SYNC_LIM);
  localparam logic [DW-1:0]   PH_MAX = {DW{1'b1}};
  localparam logic [SC_W-1:0] SC_END = SC_W'(SYNC_LIM - 1);

  logic [PW-1:0]   psc_q;
  logic [DW-1:0]   phase_q;
  logic [SC_W-1:0] sc_q;
  logic            lost_q;
  logic            step;
  logic            restart;

  assign step    = (psc_q == psc_i);
  assign restart = ext_mode_i && sync_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q   <= '0;
      phase_q <= '0;
      sc_q    <= '0;
      lost_q  <= 1'b0;
    end else if (!go_i || restart) begin
      psc_q   <= '0;
      phase_q <= '0;
      sc_q    <= '0;
      lost_q  <= 1'b0;
    end else begin
      psc_q <= step ? '0 : psc_q + 1'b1;
      if (step && !(ext_mode_i && phase_q == PH_MAX)) phase_q <= phase_q + 1'b1;
      if (!ext_mode_i) begin
        sc_q   <= '0;
        lost_q <= 1'b0;
      end else if (sc_q == SC_END) begin
        lost_q <= 1'b1;
      end else begin
        sc_q <= sc_q + 1'b1;
      end
    end
  end

  // shadow load: idle, sync restart, or internal wrap
  assign load_o  = !go_i || restart || (!ext_mode_i && step && phase_q == PH_MAX);
  assign run_o   = go_i && !lost_q;
  assign phase_o = phase_q;
  assign lost_o  = lost_q;

  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i && !ext_mode_i && step && phase_q == PH_MAX |=> phase_q == '0);
  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i && ext_mode_i && sync_rise_i |=> phase_q == '0);
  a_r8_lost_ext_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lost_q) |-> $past(ext_mode_i) && $past(go_i));
endmodule

// File: rtl/dim_chan.sv
module dim_chan #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] master_i,
  input  logic [DW-1:0] off_i,
  input  logic [DW-1:0] phase_i,
  input  logic          load_i,
  input  logic          run_i,
  output logic          pwm_o
);
  logic signed [DW+1:0] sum;
  logic [DW-1:0]        sat;
  logic [DW-1:0]        shadow_q;

  assign sum = $signed({2'b00, master_i}) + $signed({{2{off_i[DW-1]}}, off_i});

  always_comb begin
    if (sum[DW+1])    sat = '0;
    else if (sum[DW]) sat = '1;
    else              sat = sum[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      pwm_o    <= 1'b0;
    end else begin
      if (load_i) shadow_q <= sat;
      pwm_o <= run_i && ((shadow_q == '1) || (phase_i < shadow_q));
    end
  end
endmodule

// File: rtl/dim_pwm_bank.sv
module dim_pwm_bank
  import dim_pkg::*;
#(
  parameter int N  = CH_N,
  parameter int DW = DUTY_W,
  parameter int PW = PSC_W,
  parameter int TW = TMO_W,
  parameter int AW = ADDR_W,
  parameter int WW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          lamp_on_i,
  input  logic          sync_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [WW-1:0] wdata_i,
  output logic [N-1:0]  pwm_o,
  output logic [2:0]    status_o
);
  ctrl_t                ctrl;
  logic                 fault_clr;
  logic [DW-1:0]        master;
  logic [N-1:0][DW-1:0] off;
  logic [PW-1:0]        psc;
  logic [TW-1:0]        tmo;
  logic                 lamp_s, sync_s, sync_d;
  logic                 en_eff, fault, go, lost, run, load;
  logic [DW-1:0]        phase;

  dim_regs #(.N(N), .DW(DW), .PW(PW), .TW(TW), .AW(AW), .WW(WW), .OBASE(OFF_BASE)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .ctrl_o(ctrl), .fault_clr_o(fault_clr), .master_o(master),
    .off_o(off), .psc_o(psc), .tmo_o(tmo)
  );

  dim_sync2 #(.STAGES(2)) u_sync_lamp (.clk_i, .rst_ni, .d_i(lamp_on_i), .q_o(lamp_s));
  dim_sync2 #(.STAGES(2)) u_sync_ext  (.clk_i, .rst_ni, .d_i(sync_i),    .q_o(sync_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_d <= 1'b0;
    else         sync_d <= sync_s;
  end

  assign en_eff = en_i && ctrl.en;

  dim_fault #(.TW(TW)) u_fault (
    .clk_i, .rst_ni, .en_i(en_eff), .lamp_i(lamp_s), .clr_i(fault_clr),
    .tmo_i(tmo), .fault_o(fault)
  );

  assign go = en_eff && !fault;

  dim_timebase #(.DW(DW), .PW(PW), .SYNC_LIM(SYNC_LIMIT)) u_tb (
    .clk_i, .rst_ni, .go_i(go), .ext_mode_i(ctrl.ext),
    .sync_rise_i(sync_s && !sync_d), .psc_i(psc),
    .phase_o(phase), .load_o(load), .run_o(run), .lost_o(lost)
  );

  for (genvar k = 0; k < N; k++) begin : g_ch
    dim_chan #(.DW(DW)) u_ch (
      .clk_i, .rst_ni, .master_i(master), .off_i(off[k]), .phase_i(phase),
      .load_i(load), .run_i(run), .pwm_o(pwm_o[k])
    );
  end

  assign status_o = {en_eff, lost, fault};

  a_r6_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> pwm_o == '0);
  a_r9_fault_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] |=> pwm_o == '0);
  a_r8_lost_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1] |=> pwm_o == '0);
endmodule

// File: tb/dim_pwm_bank_test.sv
module dim_pwm_bank_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        lamp_on_i = 1'b0;
  logic        sync_i = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [7:0]  pwm_o;
  logic [2:0]  status_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit sync_run = 1'b0;
  int sync_period = 200;
  int cnt [8];

  dim_pwm_bank uut (
    .clk_i(clk), .rst_ni, .en_i, .lamp_on_i, .sync_i,
    .we_i, .addr_i, .wdata_i, .pwm_o, .status_o
  );

  always #2 clk = ~clk;

  // master, first offset, offset step per channel, prescale
  localparam int NV = 9;
  localparam int VM [NV] = '{128, 100, 250,  10,   0, 255, 255,  64, 200};
  localparam int VO [NV] = '{  0, -40,   0, -30,   0,   0, -10,   0, 127};
  localparam int VS [NV] = '{  0,  10,   3,   5,   0,   0,   1,   8,   0};
  localparam int VP [NV] = '{  0,   0,   0,   0,   0,   0,   0,   1,   2};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we_i = 1'b1; addr_i = 4'(a); wdata_i = 16'(d);
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic measure(input int win);
    for (int k = 0; k < 8; k++) cnt[k] = 0;
    repeat (win) begin
      @(negedge clk);
      for (int k = 0; k < 8; k++) cnt[k] += int'(pwm_o[k]);
    end
  endtask

  function automatic int clamp(input int v);
    return (v < 0) ? 0 : (v > 255) ? 255 : v;
  endfunction

  initial begin
    forever begin
      if (sync_run) begin
        sync_i = 1'b1;
        repeat (4) @(negedge clk);
        sync_i = 1'b0;
        repeat (sync_period - 4) @(negedge clk);
      end else @(negedge clk);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 pwm in reset", int'(pwm_o), 0);
    chk("R11 status in reset", int'(status_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 pwm after reset", int'(pwm_o), 0);
    chk("R11 status after reset", int'(status_o), 0);

    lamp_on_i = 1'b1;
    wr(0, 1);
    en_i = 1'b1;
    @(negedge clk);
    chk("R6 status enable bit", int'(status_o), 4);

    // table: R1 R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      int frame;
      frame = 256 * (VP[v] + 1);
      wr(1, VM[v]);
      wr(2, VP[v]);
      for (int k = 0; k < 8; k++) wr(8 + k, (VO[v] + k * VS[v]) & 8'hFF);
      repeat (3 * frame) @(negedge clk);
      measure(frame);
      for (int k = 0; k < 8; k++) begin
        int o, e;
        o = int'($signed(8'((VO[v] + k * VS[v]) & 8'hFF)));
        e = clamp(VM[v] + o);
        e = (e == 255) ? frame : e * (VP[v] + 1);
        chk($sformatf("R1 R3 R4 vec %0d ch %0d high clocks", v, k), cnt[k], e);
      end
    end

    // R5: mid-frame master change deferred
    wr(2, 0);
    for (int k = 0; k < 8; k++) wr(8 + k, 0);
    wr(1, 200);
    @(negedge clk); en_i = 1'b0;
    @(negedge clk); en_i = 1'b1;
    repeat (100) @(negedge clk);
    wr(1, 10);
    repeat (50) @(negedge clk);
    chk("R5 old duty kept in frame", int'(pwm_o), 255);
    repeat (256) @(negedge clk);
    chk("R5 new duty next frame", int'(pwm_o), 0);

    // R6 / R2 full on, then gating
    wr(1, 255);
    repeat (600) @(negedge clk);
    chk("R2 duty 255 steady high", int'(pwm_o), 255);
    en_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 en_i low outputs", int'(pwm_o), 0);
    chk("R6 en_i low status", int'(status_o), 0);
    en_i = 1'b1;
    wr(0, 0);
    repeat (2) @(negedge clk);
    chk("R6 soft enable low outputs", int'(pwm_o), 0);
    chk("R6 soft enable low status", int'(status_o), 0);
    wr(0, 1);

    // R7 / R8: external sync, period 200
    wr(1, 100);
    sync_period = 200;
    sync_run = 1'b1;
    wr(0, 3);
    repeat (800) @(negedge clk);
    measure(200);
    chk("R7 ext duty 100 of 200", cnt[0], 100);
    chk("R7 ext duty 100 ch7", cnt[7], 100);
    wr(1, 220);
    repeat (800) @(negedge clk);
    measure(200);
    chk("R7 ext restart before 220", cnt[3], 200);
    chk("R7 status no loss", int'(status_o), 4);
    sync_run = 1'b0;
    repeat (900) @(negedge clk);
    chk("R8 lost status", int'(status_o), 6);
    chk("R8 lost outputs", int'(pwm_o), 0);
    sync_run = 1'b1;
    repeat (800) @(negedge clk);
    chk("R8 recovered status", int'(status_o), 4);
    measure(200);
    chk("R8 recovered output", cnt[5], 200);
    sync_run = 1'b0;
    repeat (250) @(negedge clk);
    wr(0, 1);

    // R9 / R10: lamp fault
    wr(1, 128);
    wr(3, 100);
    lamp_on_i = 1'b0;
    @(negedge clk); en_i = 1'b0;
    @(negedge clk); en_i = 1'b1;
    repeat (50) @(negedge clk);
    chk("R9 no fault before timeout", int'(status_o), 4);
    repeat (100) @(negedge clk);
    chk("R9 fault after timeout", int'(status_o), 5);
    chk("R9 outputs low on fault", int'(pwm_o), 0);
    lamp_on_i = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10 lamp return keeps fault", int'(status_o), 5);
    wr(0, 5);
    repeat (3) @(negedge clk);
    chk("R10 clear bit clears fault", int'(status_o), 4);
    repeat (600) @(negedge clk);
    measure(256);
    chk("R10 running after clear", cnt[0], 128);
    lamp_on_i = 1'b0;
    @(negedge clk); en_i = 1'b0;
    @(negedge clk); en_i = 1'b1;
    repeat (150) @(negedge clk);
    chk("R9 fault again", int'(status_o), 5);
    en_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 enable drop clears fault", int'(status_o), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule